// File: doc/BRIEF.md
# Cascade-Gated Countdown Timer

This block is one down-counting timer channel. A programmable reload value is the period. Software-style pulses start and stop the channel, and a write port loads the running count directly. The count steps down by one on every qualified clock. From zero it either reloads and keeps running or halts, as the auto-disable and auto-deactivate options decide. A one-clock done pulse marks each terminal tick when interrupts are enabled.

Three cascade inputs shape counting. Each one picks its own line from a vector of external event lines, passes through a two-flop synchronizer and can be inverted. Inputs 0 and 1 qualify counting. Each can be enabled alone, or the two can be combined by AND or OR, and either can be put in trigger mode. In trigger mode the input only has to be seen active once while the channel runs. Input 2 is a stop request. It acts on its level at any time or, in terminal mode, only when the count is at zero.

All pins are plain control and status levels or pulses. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `cdt_channel`

## Requirements
- R1: After reset, count is 0 and enabled, active and done are all 0.
- R2: A cycle with cnt_wr high loads cnt_wdata into the count at the next clock edge, taking priority over any decrement or reload in that cycle.
- R3: While enabled and active with counting qualified, the count drops by one per clock. The clock edge at which it is at 0 (the terminal tick) loads reload_val instead, so one period is reload_val+1 qualified clocks.
- R4: A stop_req pulse clears enabled and active at the next edge, and stop_req wins over a simultaneous start. While enabled is 0 the count holds its value.
- R5: When csd_gate_en bit k (k = 0 or 1) is set, the count moves only while cascade k is active. Cascade k is bit csd_selk of evt_in after two synchronizer flops. Setting csd_inv bit k makes it active low.
- R6: With both gate enables set, csd_dual_or = 0 needs both cascades active (AND) and csd_dual_or = 1 needs either (OR).
- R7: With csd_trig bit k set, once cascade k has been seen active while the channel runs, its level is ignored until the channel stops. A new start needs a new activation.
- R8: With csd_stop_en = 1 and csd_stop_trig = 0, an active cascade 2 clears enabled and active at any count, and the count then freezes.
- R9: With csd_stop_en = 1 and csd_stop_trig = 1, cascade 2 has no effect at a nonzero count. If it is active at the terminal tick, enabled and active clear and the count stays 0.
- R10: With cfg_auto_dis = 1, the terminal tick clears enabled and active and leaves the count at 0.
- R11: With cfg_auto_dis = 0 and cfg_auto_deact = 1, the terminal tick clears active only. Enabled stays 1 and the count stays 0.
- R12: With cfg_irq_en = 1, done is high for the one clock that follows each terminal tick. With cfg_irq_en = 0, done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: set enabled and active |
| stop_req | input | 1 | Pulse: clear enabled and active |
| cnt_wr | input | 1 | Load cnt_wdata into the count |
| cnt_wdata | input | CNT_W | Value for a count write |
| reload_val | input | CNT_W | Value loaded at the terminal tick |
| cfg_auto_dis | input | 1 | Terminal tick clears enabled and active |
| cfg_auto_deact | input | 1 | Terminal tick clears active only |
| cfg_irq_en | input | 1 | Allow the done pulse |
| evt_in | input | N_EVT | External event lines |
| csd_sel0 | input | SEL_W | Event line for cascade 0 |
| csd_sel1 | input | SEL_W | Event line for cascade 1 |
| csd_sel2 | input | SEL_W | Event line for cascade 2 |
| csd_gate_en | input | 2 | Gate enables for cascades 0 and 1 |
| csd_inv | input | 3 | Active-low select for each cascade |
| csd_dual_or | input | 1 | 0: AND, 1: OR when both gates are enabled |
| csd_trig | input | 2 | Trigger mode for cascades 0 and 1 |
| csd_stop_en | input | 1 | Cascade 2 acts as a stop request |
| csd_stop_trig | input | 1 | Cascade 2 stops only at the terminal tick |
| count | output | CNT_W | Current count |
| enabled | output | 1 | Enable state |
| active | output | 1 | Active state |
| done | output | 1 | One-clock terminal pulse |

## Verification
The hardest case to reach is the terminal-only stop. Cascade 2 must already be active, through the synchronizer, when the count lands on zero, and it must provably do nothing at the counts before that. The stimulus raises the event line and lets it settle while terminal mode is selected, then starts a short count. It checks that the channel is still enabled one clock before zero and halted at the terminal tick. The run is then repeated with the line low, to show that the channel reloads instead. Trigger latching is reached in a similar way: a short event burst while running, followed by a restart with the line low.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // Cascade configuration gathered into one bundle for internal use
  typedef struct packed {
    logic [1:0] gate_en;
    logic [2:0] inv;
    logic       dual_or;
    logic [1:0] trig;
    logic       stop_en;
    logic       stop_trig;
  } cdt_csd_t;

  localparam int unsigned CDT_NUM_CSD  = 3;
  localparam int unsigned CDT_NUM_GATE = 2;

endpackage

// File: rtl/cdt_sync.sv
module cdt_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/cdt_qual.sv
module cdt_qual
  import cdt_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_s,
  input  logic [SEL_W-1:0] sel0,
  input  logic [SEL_W-1:0] sel1,
  input  logic [SEL_W-1:0] sel2,
  input  cdt_csd_t         cfg,
  input  logic             running,
  input  logic             start,
  output logic             gate_ok,
  output logic             c2_on
);

  logic [CDT_NUM_CSD-1:0][SEL_W-1:0] sel_arr;
  logic [CDT_NUM_CSD-1:0]            sig;
  logic [CDT_NUM_GATE-1:0]           seen_q;
  logic [CDT_NUM_GATE-1:0]           term;

  assign sel_arr = {sel2, sel1, sel0};

  // Source selection and polarity for every cascade input
  for (genvar k = 0; k < CDT_NUM_CSD; k++) begin : g_src
    assign sig[k] = evt_s[sel_arr[k]] ^ cfg.inv[k];
  end

  // Trigger latches for the two gating inputs
  for (genvar k = 0; k < CDT_NUM_GATE; k++) begin : g_gate
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 seen_q[k] <= 1'b0;
      else if (start || !running) seen_q[k] <= 1'b0;
      else if (sig[k])            seen_q[k] <= 1'b1;
    end
    assign term[k] = sig[k] | (cfg.trig[k] & seen_q[k]);
  end

  always_comb begin
    if (&cfg.gate_en) begin
      gate_ok = cfg.dual_or ? (term[0] | term[1]) : (term[0] & term[1]);
    end else begin
      gate_ok = (~cfg.gate_en[0] | term[0]) & (~cfg.gate_en[1] | term[1]);
    end
  end

  assign c2_on = sig[2];

endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_req,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             auto_dis,
  input  logic             auto_deact,
  input  logic             irq_en,
  input  logic             gate_ok,
  input  logic             c2_on,
  input  logic             stop_en,
  input  logic             stop_trig,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             enabled,
  output logic             active,
  output logic             done
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             act_q;
  logic             done_q;
  logic             run;
  logic             tick_end;
  logic             halt_all;
  logic             deact;

  assign running  = en_q & act_q;
  assign run      = running & gate_ok;
  assign tick_end = run & (cnt_q == ZERO);
  assign halt_all = stop_req
                  | (stop_en & ~stop_trig & c2_on)
                  | (tick_end & auto_dis)
                  | (tick_end & stop_en & stop_trig & c2_on);
  assign deact    = tick_end & auto_deact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cnt_wr)                      cnt_q <= cnt_wdata;
      else if (tick_end)               cnt_q <= (halt_all || deact) ? ZERO : reload_val;
      else if (run)                    cnt_q <= cnt_q - ONE;

      if (halt_all)                    en_q <= 1'b0;
      else if (start)                  en_q <= 1'b1;

      if (halt_all || deact)           act_q <= 1'b0;
      else if (start)                  act_q <= 1'b1;

      done_q <= irq_en & tick_end;
    end
  end

  assign count   = cnt_q;
  assign enabled = en_q;
  assign active  = act_q;
  assign done    = done_q;

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_EVT = 8,
  parameter int SEL_W = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_req,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             cfg_auto_dis,
  input  logic             cfg_auto_deact,
  input  logic             cfg_irq_en,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [SEL_W-1:0] csd_sel0,
  input  logic [SEL_W-1:0] csd_sel1,
  input  logic [SEL_W-1:0] csd_sel2,
  input  logic [1:0]       csd_gate_en,
  input  logic [2:0]       csd_inv,
  input  logic             csd_dual_or,
  input  logic [1:0]       csd_trig,
  input  logic             csd_stop_en,
  input  logic             csd_stop_trig,
  output logic [CNT_W-1:0] count,
  output logic             enabled,
  output logic             active,
  output logic             done
);

  cdt_csd_t         csd_cfg;
  logic [N_EVT-1:0] evt_s;
  logic             gate_ok;
  logic             c2_on;
  logic             running;

  assign csd_cfg = '{gate_en:   csd_gate_en,
                     inv:       csd_inv,
                     dual_or:   csd_dual_or,
                     trig:      csd_trig,
                     stop_en:   csd_stop_en,
                     stop_trig: csd_stop_trig};

  cdt_sync #(.W(N_EVT)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (evt_in),
    .q    (evt_s)
  );

  cdt_qual #(.N_EVT(N_EVT), .SEL_W(SEL_W)) qual_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_s  (evt_s),
    .sel0   (csd_sel0),
    .sel1   (csd_sel1),
    .sel2   (csd_sel2),
    .cfg    (csd_cfg),
    .running(running),
    .start  (start),
    .gate_ok(gate_ok),
    .c2_on  (c2_on)
  );

  cdt_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop_req  (stop_req),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .reload_val(reload_val),
    .auto_dis  (cfg_auto_dis),
    .auto_deact(cfg_auto_deact),
    .irq_en    (cfg_irq_en),
    .gate_ok   (gate_ok),
    .c2_on     (c2_on),
    .stop_en   (csd_stop_en),
    .stop_trig (csd_stop_trig),
    .running   (running),
    .count     (count),
    .enabled   (enabled),
    .active    (active),
    .done      (done)
  );

endmodule

// File: rtl/cdt_channel_chk.sv
module cdt_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             cfg_auto_dis,
  input logic             cfg_auto_deact,
  input logic             cfg_irq_en,
  input logic [CNT_W-1:0] count,
  input logic             enabled,
  input logic             active,
  input logic             done
);

  a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && active && !cnt_wr && count != '0)
      |=> (count == $past(count) || count == $past(count) - CNT_W'(1)));

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !cnt_wr) |=> count == $past(count));

  a_r10_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cfg_auto_dis)) |-> (!enabled && !active && count == '0));

  a_r11_deactivate: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cfg_auto_deact)) |-> !active);

  a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cfg_irq_en));

endmodule

bind cdt_channel cdt_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cnt_wr        (cnt_wr),
  .cnt_wdata     (cnt_wdata),
  .cfg_auto_dis  (cfg_auto_dis),
  .cfg_auto_deact(cfg_auto_deact),
  .cfg_irq_en    (cfg_irq_en),
  .count         (count),
  .enabled       (enabled),
  .active        (active),
  .done          (done)
);

// File: tb/cdt_channel_tb_top.sv
`timescale 1ns/1ps
module cdt_channel_tb_top;

  localparam int CNT_W = 32;
  localparam int N_EVT = 8;
  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start, stop_req, cnt_wr;
  logic [CNT_W-1:0] cnt_wdata, reload_val;
  logic             cfg_auto_dis, cfg_auto_deact, cfg_irq_en;
  logic [N_EVT-1:0] evt_in;
  logic [SEL_W-1:0] csd_sel0, csd_sel1, csd_sel2;
  logic [1:0]       csd_gate_en, csd_trig;
  logic [2:0]       csd_inv;
  logic             csd_dual_or, csd_stop_en, csd_stop_trig;
  logic [CNT_W-1:0] count;
  logic             enabled, active, done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // Scoreboard: expected done events with the count visible alongside them
  string          exp_tag_q[$];
  logic [CNT_W-1:0] exp_cnt_q[$];

  always #10 clk = ~clk;

  cdt_channel #(.CNT_W(CNT_W), .N_EVT(N_EVT), .SEL_W(SEL_W)) dut_i (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_done(string tag, logic [CNT_W-1:0] c);
    exp_tag_q.push_back(tag);
    exp_cnt_q.push_back(c);
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [CNT_W-1:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; nclk(1); cnt_wr = 1'b0;
  endtask

  task automatic go();
    start = 1'b1; nclk(1); start = 1'b0;
  endtask

  task automatic halt();
    stop_req = 1'b1; nclk(1); stop_req = 1'b0;
  endtask

  // Monitor: every done pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (exp_tag_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R12 unexpected done actual=1 expected=0");
      end else begin
        chk({exp_tag_q.pop_front(), " done count"}, count, exp_cnt_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] c;
    rst_n = 1'b0; start = 0; stop_req = 0; cnt_wr = 0; cnt_wdata = '0;
    reload_val = '0; cfg_auto_dis = 0; cfg_auto_deact = 0; cfg_irq_en = 0;
    evt_in = '0; csd_sel0 = 3'd3; csd_sel1 = 3'd5; csd_sel2 = 3'd6;
    csd_gate_en = '0; csd_trig = '0; csd_inv = '0; csd_dual_or = 0;
    csd_stop_en = 0; csd_stop_trig = 0;
    nclk(3); rst_n = 1'b1; nclk(1);

    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 enabled", enabled, 0);
    chk("R1 active", active, 0);
    chk("R1 done", done, 0);

    // R3 / R12 free-running period with reload
    reload_val = 4; cfg_irq_en = 1;
    wr(2);
    chk("R2 load while idle", count, 2);
    push_done("R12", 4);
    go();
    chk("R3 enabled after start", enabled, 1);
    nclk(3);
    nclk(1); chk("R3 after reload", count, 3);
    // R2 priority over decrement
    cnt_wr = 1; cnt_wdata = 77; nclk(1); cnt_wr = 0;
    chk("R2 write beats decrement", count, 77);
    nclk(1); chk("R3 step", count, 76);
    // R4 stop and freeze
    halt();
    chk("R4 enabled cleared", enabled, 0);
    chk("R4 count at stop", count, 75);
    nclk(3); chk("R4 count frozen", count, 75);
    start = 1; stop_req = 1; nclk(1); start = 0; stop_req = 0;
    chk("R4 stop beats start", enabled, 0);

    // R10 auto-disable
    cfg_auto_dis = 1; reload_val = 7; wr(1);
    push_done("R10", 0);
    go(); nclk(1); chk("R10 at zero", count, 0);
    nclk(1);
    chk("R10 enabled", enabled, 0);
    chk("R10 active", active, 0);
    chk("R10 count", count, 0);
    nclk(2); chk("R10 held", count, 0);
    cfg_auto_dis = 0;

    // R11 auto-deactivate
    cfg_auto_deact = 1; wr(1);
    push_done("R11", 0);
    go(); nclk(2);
    chk("R11 enabled kept", enabled, 1);
    chk("R11 active", active, 0);
    nclk(2); chk("R11 held", count, 0);
    cfg_auto_deact = 0; halt();

    // R12 no done when interrupts are off
    cfg_irq_en = 0; reload_val = 2; wr(0);
    go(); nclk(1);
    chk("R12 reload seen", count, 2);
    chk("R12 done off", done, 0);
    halt();

    // R5 single gate with polarity
    reload_val = 200; wr(200); csd_gate_en = 2'b01;
    go(); nclk(4); chk("R5 gated idle", count, 200);
    evt_in[3] = 1; nclk(4); c = count; nclk(5);
    chk("R5 gated counting", count, c - 5);
    csd_inv = 3'b001; nclk(2); c = count; nclk(5);
    chk("R5 inverted blocks", count, c);
    evt_in[3] = 0; nclk(4); c = count; nclk(4);
    chk("R5 inverted counts", count, c - 4);
    csd_inv = '0;

    // R6 AND / OR combination
    csd_gate_en = 2'b11; evt_in[3] = 1; evt_in[5] = 0; csd_dual_or = 0;
    nclk(4); c = count; nclk(4); chk("R6 AND blocks", count, c);
    csd_dual_or = 1; nclk(2); c = count; nclk(4);
    chk("R6 OR counts", count, c - 4);
    evt_in[3] = 0; nclk(4); c = count; nclk(4);
    chk("R6 OR none", count, c);
    halt(); csd_gate_en = '0; csd_dual_or = 0;

    // R7 trigger mode
    csd_gate_en = 2'b01; csd_trig = 2'b01; wr(100);
    go(); nclk(4); chk("R7 waits", count, 100);
    evt_in[3] = 1; nclk(4); evt_in[3] = 0; nclk(4);
    c = count; nclk(5); chk("R7 level ignored", count, c - 5);
    halt(); nclk(1); go(); nclk(4);
    c = count; nclk(4); chk("R7 rearmed", count, c);
    halt(); csd_gate_en = '0; csd_trig = '0;

    // R8 level stop
    csd_stop_en = 1; wr(50); go(); nclk(2);
    chk("R8 running", enabled, 1);
    evt_in[6] = 1; nclk(4);
    chk("R8 enabled", enabled, 0);
    chk("R8 active", active, 0);
    c = count; nclk(3); chk("R8 frozen", count, c);

    // R9 terminal-only stop
    csd_stop_trig = 1; reload_val = 9; cfg_irq_en = 1; wr(3);
    push_done("R9", 0);
    go(); nclk(2);
    chk("R9 nonzero ignored", enabled, 1);
    nclk(2);
    chk("R9 stopped at zero", enabled, 0);
    chk("R9 count", count, 0);
    evt_in[6] = 0; nclk(4); wr(1);
    push_done("R9", 9);
    go(); nclk(2);
    chk("R9 inactive reloads", count, 9);
    chk("R9 still enabled", enabled, 1);
    halt();

    nclk(3);
    chk("R12 all done pulses seen", exp_tag_q.size(), 0);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule